// File: doc/BRIEF.md
# SAR ADC Conversion Timing Sequencer

This block is the digital sequencer behind a successive-approximation converter. It does nothing until a trigger arrives. It then runs a fixed five-bus-cycle synchronization step and an optional startup wait for an asynchronous conversion clock. A short preparation interval and a programmable sample window follow. After that comes a most-significant-bit-first binary search, driven by an external comparator bit. When the conversion ends, the sequencer copies the search outcome into a result register and raises a one-cycle completion flag.

All conversion-clock timing is measured in half-periods. The `half_tick` input pulses once for every half period of the conversion clock, so a 3.5-cycle sample window is counted as seven half-ticks. In continuous mode the block starts the next sample window straight after each completion. These later conversions skip the synchronization, preparation and startup steps. The sample-and-hold switch, the DAC and the comparator are outside the block. The `sampling` output and the `trial` code drive them.

Top module: `adc_conv_seq`

## Requirements
- R1: In idle, `cclk_en` and `sampling` stay low and nothing changes until `trigger` is seen high at a clock edge. `cclk_en` rises only in the cycle after such an edge.
- R2: With short sampling (`long_smp`=0), a single or first conversion takes 5 bus cycles and then 2×20 half-ticks in 8-bit mode, or 2×23 half-ticks in 10- or 12-bit mode. `done` is high in the cycle after the edge that takes the last half-tick.
- R3: With long sampling (`long_smp`=1), a single or first conversion takes 5 bus cycles and then 2×40 half-ticks (8-bit) or 2×43 half-ticks (10/12-bit).
- R4: In continuous mode (`cont`=1), each later conversion starts with no new trigger. It takes 2×17 or 2×20 half-ticks with short sampling, and 2×37 or 2×40 with long sampling (8-bit or 10/12-bit), with no bus-cycle overhead.
- R5: When `clk_sel`=2'b11 at the trigger, the first conversion gets an extra 2×STARTUP_TICKS half-ticks. Later continuous conversions do not.
- R6: `sampling` is high for exactly 7 half-ticks (short) or 47 half-ticks (long). When it falls, the search begins with `trial` equal to only the top bit set.
- R7: `res_sel` 2'b00 selects 8 bits, 2'b01 selects 10 bits, and 2'b1x selects 12 bits. The result is the largest code not above the input, left-aligned in 12 bits, with the unused low bits zero. `comp`=1 means the input is at or above `trial`.
- R8: `result` changes only at a conversion's completion. During a conversion it keeps the previous value.
- R9: `done` is high for exactly one bus cycle per conversion.
- R10: A `trigger` that arrives during a conversion has no effect on its timing and does not start a further conversion.
- R11: Half-ticks are counted only when `half_tick` is high. Holding it low for G cycles after synchronization delays completion by exactly G cycles.
- R12: A low `rst_n` at a clock edge clears `result` and `done` and returns the block to idle.
- R13: `cont` is checked at each completion. If it is low there, the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trigger | input | 1 | Starts a conversion when the block is idle |
| half_tick | input | 1 | Pulse for each conversion-clock half period |
| cont | input | 1 | Continuous mode |
| long_smp | input | 1 | Selects the long sample window |
| res_sel | input | 2 | Resolution code |
| clk_sel | input | 2 | Clock source; 2'b11 adds the startup wait |
| comp | input | 1 | Comparator: input at or above trial |
| cclk_en | output | 1 | Conversion clock enable, high while busy |
| sampling | output | 1 | Sample switch closed |
| trial | output | RES_W | Code presented to the DAC |
| result | output | RES_W | Last completed conversion, left-aligned |
| done | output | 1 | One-cycle completion flag |

## Verification
Single conversions are run for every combination of resolution and sample length. The measured cycle counts separate the 8-bit search length from the 10/12-bit one and the short window from the long one. Input voltages with alternating and edge bit patterns, including all ones and a value just below a quantization step, show whether the search truncates correctly and whether the low bits are masked. Continuous runs, including one with the asynchronous clock selected, separate the first-conversion overhead from the later conversions. Runs with stalled half-ticks and with a trigger during a conversion show that only real half-ticks advance the sequence and that a busy block ignores a trigger.

// File: rtl/adc_seq_pkg.sv
// Shared types and helpers for the conversion sequencer.
// Assumes the widest resolution is 12 bits.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_WARM,
        ST_PREP,
        ST_SAMPLE,
        ST_SEARCH,
        ST_TAIL
    } seq_state_t;

    // Number of result bits for a resolution code.
    function automatic int unsigned res_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 8;
            2'b01:   return 10;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
// Phase counter: counts step strobes and flags the last one of a phase.
// Assumes len >= 1 while step can be high. The count wraps to zero on the
// last step, so the next phase always starts from zero.
module adc_seq_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    // Last step of the current phase.
    assign last = step && (cnt == len - CNT_W'(1));

    // Step counter with wrap at the phase end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= last ? '0 : cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/adc_seq_sar.sv
// Successive-approximation register. Load sets only the top bit. Each
// decide strobe keeps or clears the bit under test, based on comp, and
// sets the next lower trial bit unless lsb_pos has been reached.
// Assumes bitpos >= lsb_pos whenever decide is high.
module adc_seq_sar #(
    parameter int RES_W = 12,
    parameter int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             decide,
    input  logic             comp,
    input  logic [IDX_W-1:0] bitpos,
    input  logic [IDX_W-1:0] lsb_pos,
    output logic [RES_W-1:0] trial
);

    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    // Trial code update: load, or resolve one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial <= '0;
        end else if (load) begin
            trial <= TOP_BIT;
        end else if (decide) begin
            trial[bitpos] <= comp;
            if (bitpos > lsb_pos) begin
                trial[bitpos - IDX_W'(1)] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
// Conversion phase controller. It steps through synchronization, optional
// startup wait, preparation, sampling, search and a tail, and picks the
// phase length for the timer. Resolution and sample length are latched at
// each conversion start. The clock source is latched at the trigger only.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W         = 12,
    parameter int CNT_W         = 12,
    parameter int SYNC_CYCLES   = 5,
    parameter int STARTUP_TICKS = 10,
    parameter int PREP_HALVES   = 6,
    parameter int SHORT_HALVES  = 7,
    parameter int LONG_HALVES   = 47,
    parameter int TAIL_8        = 11,
    parameter int TAIL_10       = 13,
    parameter int TAIL_12       = 9,
    parameter int IDX_W         = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trigger,
    input  logic             half_tick,
    input  logic             cont,
    input  logic             long_smp,
    input  logic [1:0]       res_sel,
    input  logic [1:0]       clk_sel,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic             tmr_last,
    output seq_state_t       state,
    output logic             tmr_step,
    output logic             tmr_clear,
    output logic [CNT_W-1:0] tmr_len,
    output logic             sar_load,
    output logic             sar_decide,
    output logic [IDX_W-1:0] bitpos,
    output logic [IDX_W-1:0] lsb_pos,
    output logic             finish
);

    localparam logic [CNT_W-1:0] SYNC_LEN  = CNT_W'(SYNC_CYCLES);
    localparam logic [CNT_W-1:0] WARM_LEN  = CNT_W'(2 * STARTUP_TICKS);
    localparam logic [CNT_W-1:0] PREP_LEN  = CNT_W'(PREP_HALVES);
    localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(SHORT_HALVES);
    localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(LONG_HALVES);

    seq_state_t  next_state;
    logic [1:0]  res_q;
    logic        lsmp_q;
    logic        async_q;
    int unsigned nbits;
    logic        start_first;
    logic        start_next;

    assign nbits       = res_bits(res_q);
    assign start_first = (state == ST_IDLE) && trigger;
    assign start_next  = finish && cont;

    // Step source: bus cycles while synchronizing, half-ticks otherwise.
    assign tmr_step  = (state == ST_SYNC) ||
                       ((state != ST_IDLE) && half_tick);
    assign tmr_clear = (state == ST_IDLE);

    // Phase length for the current state.
    always_comb begin
        case (state)
            ST_SYNC:   tmr_len = SYNC_LEN;
            ST_WARM:   tmr_len = WARM_LEN;
            ST_PREP:   tmr_len = PREP_LEN;
            ST_SAMPLE: tmr_len = lsmp_q ? LONG_LEN : SHORT_LEN;
            ST_SEARCH: tmr_len = CNT_W'(2 * nbits);
            ST_TAIL: begin
                case (nbits)
                    8:       tmr_len = CNT_W'(TAIL_8);
                    10:      tmr_len = CNT_W'(TAIL_10);
                    default: tmr_len = CNT_W'(TAIL_12);
                endcase
            end
            default:   tmr_len = CNT_W'(1);
        endcase
    end

    // Search strobes: a decision on the second half of each bit step.
    assign sar_load   = (state == ST_SAMPLE) && tmr_last;
    assign sar_decide = (state == ST_SEARCH) && tmr_step && tmr_cnt[0];
    assign bitpos     = IDX_W'(RES_W - 1 - int'(tmr_cnt[CNT_W-1:1]));
    assign lsb_pos    = IDX_W'(RES_W - int'(nbits));
    assign finish     = (state == ST_TAIL) && tmr_last;

    // Next phase selection.
    always_comb begin
        next_state = state;
        case (state)
            ST_IDLE:   if (trigger) next_state = ST_SYNC;
            ST_SYNC:   if (tmr_last) next_state = async_q ? ST_WARM : ST_PREP;
            ST_WARM:   if (tmr_last) next_state = ST_PREP;
            ST_PREP:   if (tmr_last) next_state = ST_SAMPLE;
            ST_SAMPLE: if (tmr_last) next_state = ST_SEARCH;
            ST_SEARCH: if (tmr_last) next_state = ST_TAIL;
            ST_TAIL:   if (tmr_last) next_state = cont ? ST_SAMPLE : ST_IDLE;
            default:   next_state = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= next_state;
        end
    end

    // Configuration latch at each conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= 2'b00;
            lsmp_q  <= 1'b0;
            async_q <= 1'b0;
        end else begin
            if (start_first || start_next) begin
                res_q  <= res_sel;
                lsmp_q <= long_smp;
            end
            if (start_first) begin
                async_q <= (clk_sel == 2'b11);
            end
        end
    end

endmodule

// File: rtl/adc_conv_seq.sv
// SAR ADC conversion timing sequencer top. It ties the phase controller,
// the phase timer and the SAR register together, and holds the result
// register and the completion flag. Assumes RES_W >= 12 and that
// half_tick is a bus-synchronous strobe.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W         = 12,
    parameter int CNT_W         = 12,
    parameter int SYNC_CYCLES   = 5,
    parameter int STARTUP_TICKS = 10,
    parameter int PREP_HALVES   = 6,
    parameter int SHORT_HALVES  = 7,
    parameter int LONG_HALVES   = 47,
    parameter int TAIL_8        = 11,
    parameter int TAIL_10       = 13,
    parameter int TAIL_12       = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trigger,
    input  logic             half_tick,
    input  logic             cont,
    input  logic             long_smp,
    input  logic [1:0]       res_sel,
    input  logic [1:0]       clk_sel,
    input  logic             comp,
    output logic             cclk_en,
    output logic             sampling,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result,
    output logic             done
);

    localparam int IDX_W = $clog2(RES_W);

    seq_state_t       state;
    logic             tmr_step;
    logic             tmr_clear;
    logic [CNT_W-1:0] tmr_len;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_last;
    logic             sar_load;
    logic             sar_decide;
    logic [IDX_W-1:0] bitpos;
    logic [IDX_W-1:0] lsb_pos;
    logic             finish;

    adc_seq_ctrl #(
        .RES_W(RES_W), .CNT_W(CNT_W), .SYNC_CYCLES(SYNC_CYCLES),
        .STARTUP_TICKS(STARTUP_TICKS), .PREP_HALVES(PREP_HALVES),
        .SHORT_HALVES(SHORT_HALVES), .LONG_HALVES(LONG_HALVES),
        .TAIL_8(TAIL_8), .TAIL_10(TAIL_10), .TAIL_12(TAIL_12),
        .IDX_W(IDX_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .half_tick(half_tick),
        .cont(cont), .long_smp(long_smp), .res_sel(res_sel),
        .clk_sel(clk_sel), .tmr_cnt(tmr_cnt), .tmr_last(tmr_last),
        .state(state), .tmr_step(tmr_step), .tmr_clear(tmr_clear),
        .tmr_len(tmr_len), .sar_load(sar_load), .sar_decide(sar_decide),
        .bitpos(bitpos), .lsb_pos(lsb_pos), .finish(finish)
    );

    adc_seq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .step(tmr_step),
        .len(tmr_len), .cnt(tmr_cnt), .last(tmr_last)
    );

    adc_seq_sar #(.RES_W(RES_W), .IDX_W(IDX_W)) i_sar (
        .clk(clk), .rst_n(rst_n), .load(sar_load), .decide(sar_decide),
        .comp(comp), .bitpos(bitpos), .lsb_pos(lsb_pos), .trial(trial)
    );

    assign cclk_en  = (state != ST_IDLE);
    assign sampling = (state == ST_SAMPLE);

    // Result transfer and completion flag at the end of the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish) begin
                result <= trial;
            end
        end
    end

endmodule

// File: rtl/adc_conv_seq_chk.sv
// Property checker for the sequencer, bound to every instance of the top.
module adc_conv_seq_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trigger,
    input logic             cclk_en,
    input logic             sampling,
    input logic             done,
    input logic [RES_W-1:0] trial,
    input logic [RES_W-1:0] result
);

    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cclk_en |-> !sampling);

    assert_wake_on_trigger_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_en) |-> $past(trigger));

    assert_search_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sampling) |-> (trial == TOP_BIT));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_W(RES_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .trigger(trigger), .cclk_en(cclk_en),
    .sampling(sampling), .done(done), .trial(trial), .result(result)
);

// File: tb/test_adc_conv_seq.sv
// Directed bench for the conversion sequencer. The comparator is modelled
// from a bench input value, and half_tick is held high unless a test
// stalls it.
module test_adc_conv_seq;

    localparam int STARTUP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trigger = 1'b0;
    logic        half_tick = 1'b1;
    logic        cont = 1'b0;
    logic        long_smp = 1'b0;
    logic [1:0]  res_sel = 2'b10;
    logic [1:0]  clk_sel = 2'b00;
    logic        comp;
    logic        cclk_en;
    logic        sampling;
    logic [11:0] trial;
    logic [11:0] result;
    logic        done;
    logic [11:0] vin = 12'h000;

    int checks = 0;
    int fails = 0;
    int samp_cnt = 0;

    always #5 clk = ~clk;

    assign comp = (vin >= trial);

    adc_conv_seq #(.STARTUP_TICKS(STARTUP)) i_adc_conv_seq (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .half_tick(half_tick),
        .cont(cont), .long_smp(long_smp), .res_sel(res_sel),
        .clk_sel(clk_sel), .comp(comp), .cclk_en(cclk_en),
        .sampling(sampling), .trial(trial), .result(result), .done(done)
    );

    always @(negedge clk) if (sampling) samp_cnt++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int first_cc(input logic [1:0] r, input logic l);
        return (l ? 40 : 20) + ((r == 2'b00) ? 0 : 3);
    endfunction

    function automatic int next_cc(input logic [1:0] r, input logic l);
        return (l ? 37 : 17) + ((r == 2'b00) ? 0 : 3);
    endfunction

    function automatic logic [11:0] quant(input logic [1:0] r, input logic [11:0] v);
        case (r)
            2'b00:   return v & 12'hFF0;
            2'b01:   return v & 12'hFFC;
            default: return v;
        endcase
    endfunction

    // Reset state and idle quietness.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 done in reset", int'(done), 0);
        chk("R12 result in reset", int'(result), 0);
        chk("R12 cclk_en in reset", int'(cclk_en), 0);
        rst_n = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R1 idle cclk_en", int'(cclk_en), 0);
        chk("R1 idle sampling", int'(sampling), 0);
        chk("R1 idle done", int'(done), 0);
    endtask

    // One single conversion with optional stall and busy trigger.
    task automatic t_single(input string tag, input logic [1:0] r, input logic l,
                            input logic [1:0] cs, input logic [11:0] v,
                            input int stall_at, input int stall_len,
                            input int retrig_at);
        int n = 0;
        int exp_n;
        logic [11:0] prev;
        prev = result;
        res_sel = r; long_smp = l; clk_sel = cs; vin = v; cont = 1'b0;
        samp_cnt = 0;
        exp_n = 6 + 2 * first_cc(r, l) + ((cs == 2'b11) ? 2 * STARTUP : 0)
                + ((stall_len > 0) ? stall_len : 0);
        trigger = 1'b1;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            trigger = (n == retrig_at);
            half_tick = !(n >= stall_at && n < stall_at + stall_len);
            if (n == 10) chk({tag, " R8 result held"}, int'(result), int'(prev));
        end while (!done && n < 2000);
        half_tick = 1'b1;
        trigger = 1'b0;
        chk({tag, " cycles"}, n, exp_n);
        chk({tag, " R7 result"}, int'(result), int'(quant(r, v)));
        chk({tag, " R6 sample length"}, samp_cnt, l ? 47 : 7);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R9 done one cycle"}, int'(done), 0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({tag, " R10 back to idle"}, int'(cclk_en), 0);
    endtask

    // Continuous run: first conversion, two later ones, then stop.
    task automatic t_cont(input string tag, input logic [1:0] r, input logic l,
                          input logic [1:0] cs, input logic [11:0] v1,
                          input logic [11:0] v2, input logic [11:0] v3);
        int n = 0;
        res_sel = r; long_smp = l; clk_sel = cs; vin = v1; cont = 1'b1;
        trigger = 1'b1;
        do begin
            @(posedge clk); n++; @(negedge clk); trigger = 1'b0;
        end while (!done && n < 2000);
        chk({tag, " R5 first cycles"}, n,
            6 + 2 * first_cc(r, l) + ((cs == 2'b11) ? 2 * STARTUP : 0));
        chk({tag, " R7 first result"}, int'(result), int'(quant(r, v1)));
        vin = v2; samp_cnt = 0; n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!done && n < 2000);
        chk({tag, " R4 second cycles"}, n, 2 * next_cc(r, l));
        chk({tag, " R7 second result"}, int'(result), int'(quant(r, v2)));
        chk({tag, " R6 second sample"}, samp_cnt, l ? 47 : 7);
        vin = v3; cont = 1'b0; n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!done && n < 2000);
        chk({tag, " R4 third cycles"}, n, 2 * next_cc(r, l));
        chk({tag, " R7 third result"}, int'(result), int'(quant(r, v3)));
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({tag, " R13 stop to idle"}, int'(cclk_en), 0);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single("R2 8b short",   2'b00, 1'b0, 2'b00, 12'hA5F, 0, 0, -1);
        t_single("R2 10b short",  2'b01, 1'b0, 2'b01, 12'h3FF, 0, 0, -1);
        t_single("R2 12b short",  2'b10, 1'b0, 2'b00, 12'h555, 0, 0, -1);
        t_single("R3 8b long",    2'b00, 1'b1, 2'b10, 12'hFFF, 0, 0, -1);
        t_single("R3 12b long",   2'b11, 1'b1, 2'b00, 12'h7FF, 0, 0, -1);
        t_single("R3 10b long",   2'b01, 1'b1, 2'b00, 12'h000, 0, 0, -1);
        t_single("R5 async 10b",  2'b01, 1'b0, 2'b11, 12'h801, 0, 0, -1);
        t_single("R10 busy trig", 2'b10, 1'b0, 2'b00, 12'h123, 0, 0, 25);
        t_single("R11 stall",     2'b00, 1'b0, 2'b00, 12'hC3A, 20, 9, -1);
        t_cont("R4 8b short", 2'b00, 1'b0, 2'b00, 12'h0F0, 12'hF0F, 12'h800);
        t_cont("R4 12b long async", 2'b10, 1'b1, 2'b11, 12'hABC, 12'h001, 12'hFFE);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R12 reset clears result", int'(result), 0);
        rst_n = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule